// File: doc/BRIEF.md
# Memory Pattern Register Readout Formatter

This block models the read side of a DRAM multipurpose pattern register. Four 8-bit pattern slots sit behind a simple write port. A read strobe comes with a slot index, a return-mode select and a bus-width select. The block answers with an eight-beat burst on a 16-bit data bus, one beat per clock, framed by a valid strobe.

There are two return modes. In serial mode each beat carries one bit of the chosen pattern, most significant bit first, copied onto every active lane. In parallel mode every beat carries the whole pattern. Parallel mode may only read slot 0. The width select sets how many lanes are driven: 4, 8 or 16. A 4-lane device keeps only the upper nibble of a parallel pattern. A 16-lane device repeats the byte on both byte lanes.

Two error pulses report rejected reads. One flags a parallel read of a slot other than 0. The other flags a read that arrives while a burst is still running.

Top module: `mpr_readout`

## Requirements
- R1: While reset is held, and until the first request after reset, `dq_out`, `dq_valid`, `err_illegal` and `err_busy` are 0. After reset, slot 0 holds 8'h7F and slots 1 to 3 hold 8'h00.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored into slot `wr_loc`. A read accepted at that same edge returns the slot's previous contents.
- R3: An accepted read raises `dq_valid` in the cycle after its request edge and keeps it high for exactly 8 consecutive cycles. `dq_out` is 0 whenever `dq_valid` is low.
- R4: With `par_mode`=0 (serial), beat i (i = 0..7) drives bit (7-i) of the pattern on every active lane.
- R5: With `par_mode`=1 (parallel), every one of the 8 beats drives the same full pattern.
- R6: `width_sel` selects the driven lanes, and lanes outside the selection are 0. With 2'b00 (4 lanes), `dq_out[3:0]` is driven; in parallel mode it carries pattern bits [7:4]. With 2'b01 (8 lanes), `dq_out[7:0]` carries the pattern. With 2'b10 or 2'b11 (16 lanes), both `dq_out[7:0]` and `dq_out[15:8]` carry it.
- R7: A request with `par_mode`=1 and `rd_loc`!=0 that arrives while idle starts no burst. It raises `err_illegal` for one cycle in the cycle after the request edge, and `dq_out` stays 0.
- R8: A request at a rising edge that ends a cycle in which `dq_valid` was high is ignored. This includes the cycle that shows the last beat. It raises `err_busy` for the following cycle and leaves the running burst unchanged.
- R9: Slot contents, mode and width are sampled at the accepting edge. Writes or select changes during a burst do not alter that burst, but writes still update the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Pattern write strobe |
| wr_loc | input | 2 | Slot written |
| wr_data | input | 8 | Pattern written |
| rd_req | input | 1 | Read request strobe |
| rd_loc | input | 2 | Slot read |
| par_mode | input | 1 | 1 = parallel return, 0 = serial return |
| width_sel | input | 2 | 00 = 4 lanes, 01 = 8 lanes, 10/11 = 16 lanes |
| dq_out | output | 16 | Burst data |
| dq_valid | output | 1 | High for each of the 8 beats |
| err_illegal | output | 1 | One-cycle pulse: parallel read of a nonzero slot |
| err_busy | output | 1 | One-cycle pulse: request rejected during a burst |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `rst_n` is held low long enough for the internal two-stage release to clear all state, since checking starts as soon as the external reset rises. The bench changes every input only on the falling edge. It waits several cycles after releasing reset before the first request. Busy and illegal cases are produced by holding a request for exactly one edge at chosen beats, including the edge that ends the last beat.

// File: rtl/mpr_pkg.sv
`timescale 1ns/1ps
package mpr_pkg;
  // Lane-count selection carried with each burst.
  typedef enum logic [1:0] {
    DQW_X4   = 2'b00,
    DQW_X8   = 2'b01,
    DQW_X16  = 2'b10,
    DQW_X16B = 2'b11
  } dq_width_e;

  // Burst settings captured at the accepting edge.
  typedef struct packed {
    logic      par;
    dq_width_e width;
  } burst_cfg_t;
endpackage

// File: rtl/mpr_rst_sync.sv
`timescale 1ns/1ps
module mpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mpr_pattern_bank.sv
`timescale 1ns/1ps
module mpr_pattern_bank #(
  parameter int              PAT_W      = 8,
  parameter int              NUM_LOC    = 4,
  parameter logic [PAT_W-1:0] RESET_PAT0 = 8'h7F,
  localparam int             LOC_W      = $clog2(NUM_LOC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [PAT_W-1:0] wr_data,
  input  logic [LOC_W-1:0] rd_loc,
  output logic [PAT_W-1:0] rd_data
);
  logic [PAT_W-1:0] slot_w [NUM_LOC];

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_slot
    localparam logic [PAT_W-1:0] RST_VAL = (g == 0) ? RESET_PAT0 : '0;
    logic [PAT_W-1:0] q;
    logic [PAT_W-1:0] d;
    logic             ce;

    always_comb begin
      ce = wr_en && (wr_loc == LOC_W'(g));
      d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (ce) q <= d;
    end

    assign slot_w[g] = q;
  end

  assign rd_data = slot_w[rd_loc];
endmodule

// File: rtl/mpr_burst_seq.sv
`timescale 1ns/1ps
module mpr_burst_seq import mpr_pkg::*; #(
  parameter int  PAT_W     = 8,
  parameter int  LOC_W     = 2,
  parameter int  BURST_LEN = 8,
  localparam int BEAT_W    = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [LOC_W-1:0]  rd_loc,
  input  logic              par_mode,
  input  dq_width_e         width,
  input  logic [PAT_W-1:0]  rd_pat,
  output logic              busy,
  output logic [BEAT_W-1:0] beat,
  output logic [PAT_W-1:0]  cap_pat,
  output burst_cfg_t        cap_cfg,
  output logic              err_illegal,
  output logic              err_busy
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic              busy_q, busy_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [PAT_W-1:0]  pat_q;
  burst_cfg_t        cfg_q, cfg_d;
  logic              ill_q, ill_d;
  logic              bsy_q, bsy_d;
  logic              accept, illegal, start;

  // Next-state logic.
  always_comb begin
    accept  = rd_req && !busy_q;
    illegal = accept && par_mode && (rd_loc != '0);
    start   = accept && !illegal;

    busy_d = busy_q;
    beat_d = beat_q;
    if (start) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (busy_q) begin
      if (beat_q == LAST_BEAT) begin
        busy_d = 1'b0;
        beat_d = '0;
      end else begin
        beat_d = beat_q + BEAT_W'(1);
      end
    end

    cfg_d.par   = par_mode;
    cfg_d.width = width;
    ill_d       = illegal;
    bsy_d       = rd_req && busy_q;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      ill_q  <= 1'b0;
      bsy_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      ill_q  <= ill_d;
      bsy_q  <= bsy_d;
    end
  end

  // Burst snapshot, loaded only on an accepted legal read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      cfg_q <= '0;
    end else if (start) begin
      pat_q <= rd_pat;
      cfg_q <= cfg_d;
    end
  end

  assign busy        = busy_q;
  assign beat        = beat_q;
  assign cap_pat     = pat_q;
  assign cap_cfg     = cfg_q;
  assign err_illegal = ill_q;
  assign err_busy    = bsy_q;
endmodule

// File: rtl/mpr_lane_map.sv
`timescale 1ns/1ps
module mpr_lane_map import mpr_pkg::*; #(
  parameter int  PAT_W     = 8,
  parameter int  BURST_LEN = 8,
  localparam int BEAT_W    = $clog2(BURST_LEN),
  localparam int DQ_W      = 2 * PAT_W
) (
  input  logic              active,
  input  burst_cfg_t        cfg,
  input  logic [PAT_W-1:0]  pat,
  input  logic [BEAT_W-1:0] beat,
  output logic [DQ_W-1:0]   dq
);
  localparam int HALF   = PAT_W / 2;
  localparam int NGRP   = DQ_W / HALF;
  localparam int GW     = $clog2(NGRP + 1);

  logic              ser_bit;
  logic [BEAT_W-1:0] bit_idx;
  logic [GW-1:0]     n_on;

  always_comb begin
    bit_idx = BEAT_W'(PAT_W - 1) - beat;
    ser_bit = pat[bit_idx];
    case (cfg.width)
      DQW_X4:  n_on = GW'(1);
      DQW_X8:  n_on = GW'(2);
      default: n_on = GW'(NGRP);
    endcase
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam bit UPPER = (g % 2) == 1;
    logic [HALF-1:0] par_val;
    logic            on;

    always_comb begin
      if (cfg.width == DQW_X4 || UPPER) par_val = pat[PAT_W-1 -: HALF];
      else                              par_val = pat[HALF-1:0];
      on = active && (GW'(g) < n_on);
    end

    assign dq[g*HALF +: HALF] = !on    ? '0 :
                                cfg.par ? par_val : {HALF{ser_bit}};
  end
endmodule

// File: rtl/mpr_readout.sv
`timescale 1ns/1ps
module mpr_readout import mpr_pkg::*; #(
  parameter int               PAT_W      = 8,
  parameter int               NUM_LOC    = 4,
  parameter int               BURST_LEN  = 8,
  parameter logic [PAT_W-1:0] RESET_PAT0 = 8'h7F,
  parameter int               RST_STAGES = 2,
  localparam int              LOC_W      = $clog2(NUM_LOC),
  localparam int              DQ_W       = 2 * PAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [PAT_W-1:0] wr_data,
  input  logic             rd_req,
  input  logic [LOC_W-1:0] rd_loc,
  input  logic             par_mode,
  input  logic [1:0]       width_sel,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_valid,
  output logic             err_illegal,
  output logic             err_busy
);
  localparam int BEAT_W = $clog2(BURST_LEN);

  logic              rst_int_n;
  logic [PAT_W-1:0]  slot_pat;
  logic              busy;
  logic [BEAT_W-1:0] beat;
  logic [PAT_W-1:0]  cap_pat;
  burst_cfg_t        cap_cfg;

  mpr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mpr_pattern_bank #(
    .PAT_W      (PAT_W),
    .NUM_LOC    (NUM_LOC),
    .RESET_PAT0 (RESET_PAT0)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_loc  (wr_loc),
    .wr_data (wr_data),
    .rd_loc  (rd_loc),
    .rd_data (slot_pat)
  );

  mpr_burst_seq #(
    .PAT_W     (PAT_W),
    .LOC_W     (LOC_W),
    .BURST_LEN (BURST_LEN)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rd_req      (rd_req),
    .rd_loc      (rd_loc),
    .par_mode    (par_mode),
    .width       (dq_width_e'(width_sel)),
    .rd_pat      (slot_pat),
    .busy        (busy),
    .beat        (beat),
    .cap_pat     (cap_pat),
    .cap_cfg     (cap_cfg),
    .err_illegal (err_illegal),
    .err_busy    (err_busy)
  );

  mpr_lane_map #(
    .PAT_W     (PAT_W),
    .BURST_LEN (BURST_LEN)
  ) u_map (
    .active (busy),
    .cfg    (cap_cfg),
    .pat    (cap_pat),
    .beat   (beat),
    .dq     (dq_out)
  );

  assign dq_valid = busy;
endmodule

// File: rtl/mpr_readout_chk.sv
`timescale 1ns/1ps
module mpr_readout_chk #(
  parameter int DQ_W      = 16,
  parameter int BURST_LEN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DQ_W-1:0] dq_out,
  input logic            dq_valid,
  input logic            err_illegal,
  input logic            err_busy
);
  localparam int CW = $clog2(BURST_LEN + 1) + 1;

  // Consecutive valid cycles seen before the current one.
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (dq_valid) run_q <= run_q + CW'(1);
    else               run_q <= '0;
  end

  // R3
  burst_not_too_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> (run_q < CW'(BURST_LEN)));

  // R3
  burst_full_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dq_valid && run_q != '0) |-> (run_q == CW'(BURST_LEN)));

  // R3
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid |-> (dq_out == '0));

  // R7
  illegal_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> (!dq_valid && !err_busy));

  // R8
  busy_only_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy |-> $past(dq_valid));
endmodule

bind mpr_readout mpr_readout_chk #(
  .DQ_W      (DQ_W),
  .BURST_LEN (BURST_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dq_out      (dq_out),
  .dq_valid    (dq_valid),
  .err_illegal (err_illegal),
  .err_busy    (err_busy)
);

// File: tb/mpr_readout_test.sv
`timescale 1ns/1ps
module mpr_readout_test;
  localparam realtime CLK_PERIOD = 5ns;
  localparam int      WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_loc;
  logic [7:0]  wr_data;
  logic        rd_req;
  logic [1:0]  rd_loc;
  logic        par_mode;
  logic [1:0]  width_sel;
  logic [15:0] dq_out;
  logic        dq_valid;
  logic        err_illegal;
  logic        err_busy;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mpr_readout uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_loc      (wr_loc),
    .wr_data     (wr_data),
    .rd_req      (rd_req),
    .rd_loc      (rd_loc),
    .par_mode    (par_mode),
    .width_sel   (width_sel),
    .dq_out      (dq_out),
    .dq_valid    (dq_valid),
    .err_illegal (err_illegal),
    .err_busy    (err_busy)
  );

  // {par[12], width[11:10], loc[9:8], pattern[7:0]}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 2'b01, 2'd1, 8'hA5},
    {1'b0, 2'b00, 2'd2, 8'h3C},
    {1'b0, 2'b10, 2'd3, 8'h81},
    {1'b1, 2'b01, 2'd0, 8'hE7},
    {1'b1, 2'b10, 2'd0, 8'h5A},
    {1'b1, 2'b00, 2'd0, 8'hD2},
    {1'b0, 2'b10, 2'd0, 8'h0F},
    {1'b1, 2'b11, 2'd0, 8'h69}
  };

  // Expected bus value for one beat, from R4, R5 and R6.
  function automatic logic [15:0] exp_dq(logic par, logic [1:0] w, logic [7:0] pat, int i);
    logic b;
    b = pat[7-i];
    if (par) begin
      case (w)
        2'b00:   return {12'h000, pat[7:4]};
        2'b01:   return {8'h00, pat};
        default: return {pat, pat};
      endcase
    end else begin
      case (w)
        2'b00:   return {12'h000, {4{b}}};
        2'b01:   return {8'h00, {8{b}}};
        default: return {16{b}};
      endcase
    end
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_loc = '0; wr_data = '0;
    rd_req = 1'b0; rd_loc = '0; par_mode = 1'b0; width_sel = 2'b01;
  endtask

  task automatic do_write(logic [1:0] loc, logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_loc = loc; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_req(logic par, logic [1:0] w, logic [1:0] loc);
    @(negedge clk);
    rd_req = 1'b1; rd_loc = loc; par_mode = par; width_sel = w;
  endtask

  task automatic watch_burst(logic par, logic [1:0] w, logic [7:0] pat, string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) begin rd_req = 1'b0; wr_en = 1'b0; end
      check("R3 valid", {15'b0, dq_valid}, 16'h1);
      check(req, dq_out, exp_dq(par, w, pat, i));
    end
    @(negedge clk);
    check("R3 valid drop", {15'b0, dq_valid}, 16'h0);
    check("R3 idle data", dq_out, 16'h0);
  endtask

  task automatic run_burst(logic par, logic [1:0] w, logic [1:0] loc, logic [7:0] pat, string req);
    start_req(par, w, loc);
    watch_burst(par, w, pat, req);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check("R1 reset dq", dq_out, 16'h0);
    check("R1 reset flags", {13'b0, dq_valid, err_illegal, err_busy}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {dq_out[12:0], dq_valid, err_illegal, err_busy}, 16'h0);

    // R1: reset contents, slot 0 = 7F in 4-lane parallel, slot 2 = 00
    run_burst(1'b1, 2'b00, 2'd0, 8'h7F, "R1 slot0 reset value");
    run_burst(1'b0, 2'b01, 2'd2, 8'h00, "R1 slot2 reset value");

    // R4 R5 R6: vector table
    foreach (VEC[k]) begin
      do_write(VEC[k][9:8], VEC[k][7:0]);
      run_burst(VEC[k][12], VEC[k][11:10], VEC[k][9:8], VEC[k][7:0],
                VEC[k][12] ? "R5 R6 parallel beat" : "R4 R6 serial beat");
    end

    // R7: parallel read of slot 3
    start_req(1'b1, 2'b01, 2'd3);
    @(negedge clk);
    rd_req = 1'b0;
    check("R7 err_illegal", {15'b0, err_illegal}, 16'h1);
    check("R7 no valid", {15'b0, dq_valid}, 16'h0);
    check("R7 dq zero", dq_out, 16'h0);
    @(negedge clk);
    check("R7 pulse one cycle", {14'b0, err_illegal, dq_valid}, 16'h0);

    // R2: write and read at the same edge return the old value
    do_write(2'd1, 8'hC3);
    start_req(1'b0, 2'b01, 2'd1);
    wr_en = 1'b1; wr_loc = 2'd1; wr_data = 8'h5A;
    watch_burst(1'b0, 2'b01, 8'hC3, "R2 old value on same edge");
    run_burst(1'b0, 2'b01, 2'd1, 8'h5A, "R2 write landed");

    // R8 R9: requests and changes during a running burst
    do_write(2'd0, 8'h96);
    start_req(1'b1, 2'b10, 2'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) rd_req = 1'b0;
      if (i == 3) begin
        check("R8 err_busy raised", {15'b0, err_busy}, 16'h1);
        rd_req = 1'b0; wr_en = 1'b0; par_mode = 1'b1; width_sel = 2'b10;
      end else if (i != 0) begin
        check("R8 no spurious busy", {15'b0, err_busy}, 16'h0);
      end
      check("R3 valid", {15'b0, dq_valid}, 16'h1);
      check("R9 burst unchanged", dq_out, exp_dq(1'b1, 2'b10, 8'h96, i));
      if (i == 2) begin
        rd_req = 1'b1; rd_loc = 2'd0; par_mode = 1'b0; width_sel = 2'b00;
        wr_en = 1'b1; wr_loc = 2'd0; wr_data = 8'h00;
      end
      if (i == 7) begin
        rd_req = 1'b1; par_mode = 1'b1; width_sel = 2'b01;
      end
    end
    @(negedge clk);
    rd_req = 1'b0;
    check("R8 last-beat request rejected", {14'b0, err_busy, dq_valid}, 16'h2);
    check("R8 bus idle", dq_out, 16'h0);
    run_burst(1'b1, 2'b00, 2'd0, 8'h00, "R9 mid-burst write stored");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule